// File: doc/BRIEF.md
# Vector Register File with Mask-State Tags

This block is a small vector register file in which every register carries a 2-bit classification tag next to its data. The tag says whether the register currently holds only zeros, only ones, or a mix of both. The tag is worked out from the incoming data on every write. A mask-state query can therefore be answered from the tags alone, with no reduction over the vector data.

Software-visible behaviour is reached through three port groups:
- A write port with an index, full-width data and an enable.
- Two combinational read ports that return whole registers.
- A query port that takes one or two register indices and returns a 32-bit mask code:
  - zero when every bit is clear;
  - all ones when every bit is set;
  - one when the bits are mixed.

A two-index query treats the pair as one long concatenated register. The tag always covers the full register width.

Data flows without back-pressure. The write port accepts a write in every cycle in which the enable is high, and no ready signal exists. Read and query results are valid in the same cycle as their indices.

Top module: `vmt_regfile`

## Requirements
- R1: After reset every register reads as zero and every query returns 32'h00000000.
- R2: A write with `wr_en` high stores `wr_data` into register `wr_idx` on the rising clock edge. A read port addressing that register in the same cycle still returns the old contents.
- R3: A one-source query of a register whose bits are all 0 returns 32'h00000000.
- R4: A one-source query of a register whose bits are all 1 returns 32'hFFFFFFFF.
- R5: A one-source query of a register holding both 0 and 1 bits returns 32'h00000001. This holds even when only one bit anywhere across the full width (any lane) differs from the others.
- R6: A two-source query returns 32'h00000000 when both registers are all-zero, and 32'hFFFFFFFF when both are all-one.
- R7: A two-source query returns 32'h00000001 for every other pair: one all-zero and one all-one, or either register mixed.
- R8: With `q_single` high, `q_idx1` has no effect on `q_code`.
- R9: A query in the same cycle as a write to a queried index reflects the data being written, not the stored tag.
- R10: With `wr_en` low, no register changes, whatever `wr_idx` and `wr_data` hold.
- R11: The two read ports return the contents of their own indexed registers independently, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | IDX_W (3) | Register written |
| wr_data | input | VLEN (128) | Data written |
| rd_a_idx | input | IDX_W (3) | Read port A index |
| rd_a_data | output | VLEN (128) | Read port A data |
| rd_b_idx | input | IDX_W (3) | Read port B index |
| rd_b_data | output | VLEN (128) | Read port B data |
| q_idx0 | input | IDX_W (3) | First query index |
| q_idx1 | input | IDX_W (3) | Second query index |
| q_single | input | 1 | 1: query `q_idx0` only |
| q_code | output | 32 | Mask code: 0, FFFFFFFF or 1 |

## Verification
A tag that drifts from its register's data shows up on `q_code` in the first cycle that register is queried after the faulty write. It appears even when reads of the same register look correct, so the bench checks queries and reads side by side in every cycle.

A broken bypass shows only in the write cycle itself. A stale tag shows from the following cycle onward. Random traffic therefore mixes same-index write/query cycles with later queries.

A pair-combining fault appears only for particular tag pairs. The stimulus deliberately produces all-zero, all-one, single-bit-flipped and random data so that every tag combination is reached.

// File: rtl/vmt_pkg.sv
package vmt_pkg;
  typedef enum logic [1:0] {
    TAG_CLEAR = 2'b00,
    TAG_MIXED = 2'b01,
    TAG_SET   = 2'b11
  } tag_e;

  localparam logic [31:0] CODE_CLEAR = 32'h0000_0000;
  localparam logic [31:0] CODE_SET   = 32'hFFFF_FFFF;
  localparam logic [31:0] CODE_MIXED = 32'h0000_0001;
endpackage

// File: rtl/vmt_classify.sv
module vmt_classify #(
  parameter int LANES  = 4,
  parameter int LANE_W = 32,
  localparam int VLEN  = LANES * LANE_W
) (
  input  logic [VLEN-1:0] data,
  output logic [1:0]      tag
);
  import vmt_pkg::*;

  logic [LANES-1:0] lane_zero;
  logic [LANES-1:0] lane_ones;

  // per-lane reductions keep the tree depth at log2(LANE_W) + log2(LANES)
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_zero[l] = ~|data[l*LANE_W +: LANE_W];
    assign lane_ones[l] =  &data[l*LANE_W +: LANE_W];
  end

  always_comb begin
    if (&lane_zero)      tag = TAG_CLEAR;
    else if (&lane_ones) tag = TAG_SET;
    else                 tag = TAG_MIXED;
  end
endmodule

// File: rtl/vmt_store.sv
module vmt_store #(
  parameter int NUM_REGS = 8,
  parameter int LANES    = 4,
  parameter int LANE_W   = 32,
  localparam int VLEN    = LANES * LANE_W,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [VLEN-1:0]          wr_data,
  input  logic [1:0]               wr_tag,
  input  logic [IDX_W-1:0]         rd_a_idx,
  output logic [VLEN-1:0]          rd_a_data,
  input  logic [IDX_W-1:0]         rd_b_idx,
  output logic [VLEN-1:0]          rd_b_data,
  output logic [NUM_REGS-1:0][1:0] tags
);
  import vmt_pkg::*;

  logic [VLEN-1:0] regs [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        regs[r] <= '0;
        tags[r] <= TAG_CLEAR;
      end
    end else if (wr_en) begin
      regs[wr_idx] <= wr_data;
      tags[wr_idx] <= wr_tag;
    end
  end

  assign rd_a_data = regs[rd_a_idx];
  assign rd_b_data = regs[rd_b_idx];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
    AST_TAG_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (regs[g] == '0) == (tags[g] == TAG_CLEAR)); // R3
    AST_TAG_ONES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (&regs[g]) == (tags[g] == TAG_SET)); // R4
    AST_TAG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      tags[g] != 2'b10); // R5
    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == IDX_W'(g)) |=> $stable(regs[g])); // R10
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs[$past(wr_idx)] == $past(wr_data)); // R2
endmodule

// File: rtl/vmt_query.sv
module vmt_query #(
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][1:0] tags,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [1:0]               wr_tag,
  input  logic [IDX_W-1:0]         q_idx0,
  input  logic [IDX_W-1:0]         q_idx1,
  input  logic                     q_single,
  output logic [31:0]              q_code
);
  import vmt_pkg::*;

  logic [1:0] t0, t1, tc;

  // same-cycle write forwarding onto each query operand
  assign t0 = (wr_en && wr_idx == q_idx0) ? wr_tag : tags[q_idx0];
  assign t1 = (wr_en && wr_idx == q_idx1) ? wr_tag : tags[q_idx1];

  always_comb begin
    if (q_single)                        tc = t0;
    else if (t0 == t1 && t0 != TAG_MIXED) tc = t0;
    else                                 tc = TAG_MIXED;
  end

  always_comb begin
    case (tc)
      TAG_CLEAR: q_code = CODE_CLEAR;
      TAG_SET:   q_code = CODE_SET;
      default:   q_code = CODE_MIXED;
    endcase
  end
endmodule

// File: rtl/vmt_regfile.sv
module vmt_regfile #(
  parameter int NUM_REGS = 8,
  parameter int LANES    = 4,
  parameter int LANE_W   = 32,
  localparam int VLEN    = LANES * LANE_W,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VLEN-1:0]   wr_data,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [VLEN-1:0]   rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [VLEN-1:0]   rd_b_data,
  input  logic [IDX_W-1:0]  q_idx0,
  input  logic [IDX_W-1:0]  q_idx1,
  input  logic              q_single,
  output logic [31:0]       q_code
);
  import vmt_pkg::*;

  logic [1:0]               wr_tag;
  logic [NUM_REGS-1:0][1:0] tags;

  vmt_classify #(.LANES(LANES), .LANE_W(LANE_W)) i_classify (
    .data (wr_data),
    .tag  (wr_tag)
  );

  vmt_store #(.NUM_REGS(NUM_REGS), .LANES(LANES), .LANE_W(LANE_W)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .wr_tag    (wr_tag),
    .rd_a_idx  (rd_a_idx),
    .rd_a_data (rd_a_data),
    .rd_b_idx  (rd_b_idx),
    .rd_b_data (rd_b_data),
    .tags      (tags)
  );

  vmt_query #(.NUM_REGS(NUM_REGS)) i_query (
    .tags     (tags),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_tag   (wr_tag),
    .q_idx0   (q_idx0),
    .q_idx1   (q_idx1),
    .q_single (q_single),
    .q_code   (q_code)
  );

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    q_code == CODE_CLEAR || q_code == CODE_SET || q_code == CODE_MIXED); // R7
  AST_BYPASS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && q_single && q_idx0 == wr_idx && wr_data == '0) |-> q_code == CODE_CLEAR); // R9
  AST_BYPASS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && q_single && q_idx0 == wr_idx && (&wr_data)) |-> q_code == CODE_SET); // R9
  AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_a_idx == wr_idx) |=> (rd_a_idx != $past(rd_a_idx) || rd_a_data == $past(wr_data))); // R2
endmodule

// File: tb/test_vmt_regfile.sv
module test_vmt_regfile;
  localparam int CLK_P = 10;
  localparam int NR = 8, LN = 4, LW = 32, VW = LN * LW, IW = 3;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, q_single = 0;
  logic [IW-1:0] wr_idx = 0, rd_a_idx = 0, rd_b_idx = 0, q_idx0 = 0, q_idx1 = 0;
  logic [VW-1:0] wr_data = '0, rd_a_data, rd_b_data;
  logic [31:0] q_code;
  logic [VW-1:0] m [NR];
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  vmt_regfile #(.NUM_REGS(NR), .LANES(LN), .LANE_W(LW)) i_vmt_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .q_idx0(q_idx0), .q_idx1(q_idx1), .q_single(q_single), .q_code(q_code));

  // 0 = all clear, 3 = all set, 1 = mixed
  function automatic int cls(input logic [VW-1:0] d);
    if (d == '0) return 0;
    if (&d) return 3;
    return 1;
  endfunction

  function automatic logic [31:0] code_of(input int t);
    if (t == 0) return 32'h0;
    if (t == 3) return 32'hFFFF_FFFF;
    return 32'h1;
  endfunction

  task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // inputs already driven after negedge; check, then clock and update model
  task automatic evaluate();
    int t0, t1, te;
    string req;
    bit byp;
    #1;
    byp = wr_en && (wr_idx == q_idx0 || (!q_single && wr_idx == q_idx1));
    t0 = (wr_en && wr_idx == q_idx0) ? cls(wr_data) : cls(m[q_idx0]);
    t1 = (wr_en && wr_idx == q_idx1) ? cls(wr_data) : cls(m[q_idx1]);
    if (q_single) te = t0;
    else if (t0 == t1 && t0 != 1) te = t0;
    else te = 1;
    if (!rst_n) req = "R1";
    else if (byp) req = "R9";
    else if (q_single && q_idx1 != q_idx0) req = "R8";
    else if (q_single) req = (te == 0) ? "R3" : (te == 3) ? "R4" : "R5";
    else req = (te == 1) ? "R7" : "R6";
    chk(req, VW'(q_code), VW'(code_of(te)));
    chk((wr_en && wr_idx == rd_a_idx) ? "R2" : "R11", rd_a_data, m[rd_a_idx]);
    chk(!wr_en ? "R10" : "R11", rd_b_data, m[rd_b_idx]);
    @(posedge clk);
    if (wr_en && rst_n) m[wr_idx] = wr_data;
    @(negedge clk);
  endtask

  task automatic drive(input bit we, input int wi, input logic [VW-1:0] wd,
                       input int ra, input int rb, input int qa, input int qb, input bit qs);
    wr_en = we; wr_idx = IW'(wi); wr_data = wd;
    rd_a_idx = IW'(ra); rd_b_idx = IW'(rb);
    q_idx0 = IW'(qa); q_idx1 = IW'(qb); q_single = qs;
    evaluate();
  endtask

  function automatic logic [VW-1:0] rnd_data();
    logic [VW-1:0] d;
    case ($urandom % 4)
      0: d = '0;
      1: d = '1;
      2: for (int l = 0; l < LN; l++) d[l*LW +: LW] = $urandom;
      default: begin d = '1; d[$urandom % VW] = 1'b0; end
    endcase
    return d;
  endfunction

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    for (int r = 0; r < NR; r++) m[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state for every register
    for (int r = 0; r < NR; r++) begin
      checks++;
      if (rd_a_data !== '0 && r == 0) begin errors++; $display("FAIL R1: actual %h expected 0", rd_a_data); end
      drive(0, 0, '0, r, r, r, r, 1);
    end
    drive(1, 1, '1, 0, 1, 1, 0, 1);                 // R9 bypass all-set, R2 old read
    drive(0, 0, '1, 1, 1, 1, 0, 1);                 // R4, R10 disabled write
    drive(0, 0, '0, 0, 0, 0, 0, 1);                 // R10 reg0 still zero
    drive(1, 2, {1'b1, {(VW-1){1'b0}}}, 2, 0, 0, 0, 1); // top-lane bit
    drive(0, 0, '0, 2, 0, 2, 7, 1);                 // R5 via R8 path
    drive(0, 0, '0, 2, 0, 2, 2, 1);                 // R5
    drive(1, 3, {{(VW-1){1'b1}}, 1'b0}, 3, 0, 0, 0, 1);
    drive(0, 0, '0, 3, 1, 3, 3, 1);                 // R5 one clear bit
    drive(1, 5, '1, 5, 1, 0, 0, 1);
    drive(0, 0, '0, 5, 1, 1, 5, 0);                 // R6 both set
    drive(0, 0, '0, 0, 4, 0, 4, 0);                 // R6 both clear
    drive(0, 0, '0, 0, 1, 0, 1, 0);                 // R7 clear+set
    drive(0, 0, '0, 2, 1, 1, 2, 0);                 // R7 set+mixed
    drive(1, 4, '1, 4, 4, 0, 4, 0);                 // R9 pair bypass
    drive(0, 0, '0, 4, 0, 1, 1, 1);                 // R8 idx1 mixed ignored? idx1==idx0
    drive(0, 0, '0, 4, 0, 1, 2, 1);                 // R8
    for (int i = 0; i < 3000; i++)
      drive(($urandom % 3) != 0, int'($urandom % NR), rnd_data(),
            int'($urandom % NR), int'($urandom % NR),
            int'($urandom % NR), int'($urandom % NR), $urandom % 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule